// File: doc/BRIEF.md
# Triangular Spread-Spectrum Offset Generator

This block drives the modulation input of a clock synthesizer such as a fractional-N divider or a numerically controlled oscillator. Each reference clock cycle it presents a signed frequency offset in units of 0.01 % of the nominal frequency. The offset follows a linear triangle that repeats without pause. Spreading the clock energy over a small band in this way lowers the spectral peaks that cause EMI.

A two-bit select picks one of four profiles. Two are centred on the nominal frequency and two spread downwards only, so the average frequency sits below nominal and the peak never rises above it. A period input sets the length of one triangle in reference cycles. The slope is produced by a fractional accumulator, so the modulation rate scales with the reference clock while the amplitude does not. A one-cycle strobe marks every peak and every trough. The enable input is active high. A board that leaves it undriven should tie it high so that spreading stays on.

Changes of profile or of the enable are deferred until the offset is zero, so the offset never moves by more than one unit per cycle. The period input takes effect at once, since it only changes the slope.

Top module: `ssc_profile_gen`

## Requirements
- R1: While reset is held, and on the first sampled cycle after a synchronous reset edge, `offset_o` is 0 and `turn_o` is 0.
- R2: `mode_i` = 2'b00 selects centre spread. Over a full period the offset reaches exactly +150 and -150.
- R3: `mode_i` = 2'b01 selects centre spread. Over a full period the offset reaches exactly +50 and -50.
- R4: `mode_i` = 2'b10 selects down spread. The offset spans exactly -100 to 0 and is never positive.
- R5: `mode_i` = 2'b11 selects down spread. The offset spans exactly -300 to 0 and is never positive.
- R6: In steady state, consecutive strobes are exactly H = floor(`period_i`/2) cycles apart. Rise and fall therefore take the same time, the full period is 2H, and the offset changes by at most 1 per cycle.
- R7: When floor(`period_i`/2) is smaller than the profile span (300, 100, 100, 300 for modes 00..11), H is raised to the span, so the offset steps once every cycle.
- R8: `turn_o` is high for exactly one cycle at each direction reversal, and in that cycle `offset_o` equals the peak or the trough of the active profile.
- R9: When `spread_en_i` is low, the offset keeps running until it next reaches 0. From then on it stays 0 and `turn_o` stays low for as long as the enable is low.
- R10: A new `mode_i` or `spread_en_i` value is adopted only in a cycle where `offset_o` is 0. At any other offset, the next cycle continues the old profile within ±1.
- R11: When a profile is started, the offset begins at 0. A centre profile then rises (first nonzero value +1) and a down profile falls (first nonzero value -1).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Reference clock |
| rst_n_i | input | 1 | Synchronous reset, active low |
| mode_i | input | 2 | Profile select (00 ±1.5 %, 01 ±0.5 %, 10 -1.0 %, 11 -3.0 %) |
| spread_en_i | input | 1 | Spreading enable, active high |
| period_i | input | PER_W (16) | Triangle period in reference cycles |
| offset_o | output | OFS_W (12) | Signed frequency offset in 0.01 % units |
| turn_o | output | 1 | One-cycle strobe at each peak and trough |

## Verification
The hardest situation to reach is a configuration change that arrives while the offset is far from zero. The change must be held back, and the old profile must finish its excursion before the new one starts. The bench waits until the ±1.5 % profile reaches an offset of +120 and then switches to the narrow profile. It also drops the enable at the trough of a down profile. After each change it checks that the offset still moves by at most one unit. The clamped-slope case is reached by programming periods far shorter than twice the span, and the bench then checks that the strobe spacing equals the span.

// File: rtl/ssc_pkg.sv
// Shared profile encodings and amplitude spans (0.01 % units).
// Assumes spans fit the level width chosen by the top module.
package ssc_pkg;
    typedef enum logic [1:0] {
        SSC_CTR_WIDE   = 2'b00,
        SSC_CTR_NARROW = 2'b01,
        SSC_DN_SHALLOW = 2'b10,
        SSC_DN_DEEP    = 2'b11
    } ssc_mode_e;

    localparam int unsigned SWING_CTR_WIDE   = 300;
    localparam int unsigned SWING_CTR_NARROW = 100;
    localparam int unsigned SWING_DN_SHALLOW = 100;
    localparam int unsigned SWING_DN_DEEP    = 300;
endpackage

// File: rtl/ssc_mode_decode.sv
// Decodes a profile select into its peak-to-trough span and its direction
// class (centre or down). Purely combinational.
// Assumes LVL_W is wide enough for the largest span.
module ssc_mode_decode
    import ssc_pkg::*;
#(
    parameter int LVL_W = 10
) (
    input  ssc_mode_e          mode_i,
    output logic [LVL_W-1:0]   span_o,
    output logic               down_o
);
    // Map each profile to its span and class
    always_comb begin
        unique case (mode_i)
            SSC_CTR_WIDE:   begin span_o = LVL_W'(SWING_CTR_WIDE);   down_o = 1'b0; end
            SSC_CTR_NARROW: begin span_o = LVL_W'(SWING_CTR_NARROW); down_o = 1'b0; end
            SSC_DN_SHALLOW: begin span_o = LVL_W'(SWING_DN_SHALLOW); down_o = 1'b1; end
            default:        begin span_o = LVL_W'(SWING_DN_DEEP);    down_o = 1'b1; end
        endcase
    end
endmodule

// File: rtl/ssc_half_period.sv
// Derives the half-period (cycles per ramp) from the programmed period.
// The odd bit of the period is dropped. The result is never below the
// span, so the level steps at most once per cycle.
// Assumes PER_W >= LVL_W.
module ssc_half_period #(
    parameter int PER_W = 16,
    parameter int LVL_W = 10
) (
    input  logic [PER_W-1:0] period_i,
    input  logic [LVL_W-1:0] span_i,
    output logic [PER_W-1:0] half_o
);
    logic [PER_W-1:0] half_raw;
    logic [PER_W-1:0] span_ext;

    // Halve the period and clamp it to the span
    always_comb begin
        half_raw = period_i >> 1;
        span_ext = PER_W'(span_i);
        half_o   = (half_raw < span_ext) ? span_ext : half_raw;
    end
endmodule

// File: rtl/ssc_frac_step.sv
// Fractional slope accumulator. Each advancing cycle adds the span to an
// error term. When the term reaches the half-period, one level step is
// issued and the half-period is subtracted. Over one half-period this
// yields exactly span steps.
// Assumes half_i >= span_i (guaranteed by ssc_half_period).
module ssc_frac_step #(
    parameter int PER_W = 16,
    parameter int LVL_W = 10
) (
    input  logic             clk_i,
    input  logic             rst_n_i,
    input  logic             adv_i,
    input  logic             clr_i,
    input  logic [LVL_W-1:0] span_i,
    input  logic [PER_W-1:0] half_i,
    output logic             step_o
);
    localparam int ACC_W = PER_W + 1;

    logic [ACC_W-1:0] err_q;
    logic [ACC_W-1:0] sum;

    // Candidate error and step decision for this cycle
    always_comb begin
        sum    = err_q + ACC_W'(span_i);
        step_o = adv_i && (sum >= ACC_W'(half_i));
    end

    // Error register: cleared on profile load, advanced while running
    always_ff @(posedge clk_i) begin
        if (!rst_n_i) begin
            err_q <= '0;
        end else if (clr_i) begin
            err_q <= '0;
        end else if (adv_i) begin
            err_q <= step_o ? (sum - ACC_W'(half_i)) : sum;
        end
    end
endmodule

// File: rtl/ssc_tri_seq.sv
// Triangle level sequencer. Holds the level (0..span) and the ramp
// direction. It moves one unit per step and reverses at 0 and at span,
// flagging each reversal for one cycle.
// Assumes at most one step per cycle and a load level within 0..span.
module ssc_tri_seq #(
    parameter int LVL_W = 10
) (
    input  logic             clk_i,
    input  logic             rst_n_i,
    input  logic             load_i,
    input  logic [LVL_W-1:0] load_lvl_i,
    input  logic             load_up_i,
    input  logic             step_i,
    input  logic [LVL_W-1:0] span_i,
    output logic [LVL_W-1:0] level_o,
    output logic             turn_o
);
    logic [LVL_W-1:0] level_q;
    logic             up_q;
    logic             turn_q;
    logic [LVL_W-1:0] level_inc;
    logic [LVL_W-1:0] level_dec;

    // Neighbour levels
    always_comb begin
        level_inc = LVL_W'(level_q + 1'b1);
        level_dec = LVL_W'(level_q - 1'b1);
    end

    // Level, direction and reversal flag
    always_ff @(posedge clk_i) begin
        if (!rst_n_i) begin
            level_q <= '0;
            up_q    <= 1'b1;
            turn_q  <= 1'b0;
        end else if (load_i) begin
            level_q <= load_lvl_i;
            up_q    <= load_up_i;
            turn_q  <= 1'b0;
        end else if (step_i) begin
            if (up_q) begin
                level_q <= level_inc;
                if (level_inc == span_i) begin
                    up_q   <= 1'b0;
                    turn_q <= 1'b1;
                end else begin
                    turn_q <= 1'b0;
                end
            end else begin
                level_q <= level_dec;
                if (level_q == LVL_W'(1)) begin
                    up_q   <= 1'b1;
                    turn_q <= 1'b1;
                end else begin
                    turn_q <= 1'b0;
                end
            end
        end else begin
            turn_q <= 1'b0;
        end
    end

    assign level_o = level_q;
    assign turn_o  = turn_q;
endmodule

// File: rtl/ssc_profile_gen.sv
// Triangular spread-spectrum offset generator (top).
// Produces a signed per-cycle offset in 0.01 % units for a clock
// synthesizer's modulation input. Profile and enable changes are latched
// only where the offset is zero, so the output moves by at most 1 per cycle.
// Assumes OFS_W > LVL_W + 1 and PER_W >= LVL_W.
module ssc_profile_gen
    import ssc_pkg::*;
#(
    parameter int PER_W = 16,
    parameter int LVL_W = 10,
    parameter int OFS_W = 12
) (
    input  logic                    clk_i,
    input  logic                    rst_n_i,
    input  logic [1:0]              mode_i,
    input  logic                    spread_en_i,
    input  logic [PER_W-1:0]        period_i,
    output logic signed [OFS_W-1:0] offset_o,
    output logic                    turn_o
);
    // Index 0: active profile, index 1: requested profile
    localparam int NCFG = 2;

    ssc_mode_e        act_mode_q;
    logic             act_en_q;
    ssc_mode_e        cfg_mode [NCFG];
    logic [LVL_W-1:0] cfg_span [NCFG];
    logic             cfg_down [NCFG];

    logic [PER_W-1:0]        half;
    logic [LVL_W-1:0]        level;
    logic [LVL_W-1:0]        load_lvl;
    logic signed [OFS_W-1:0] base;
    logic                    at_zero;
    logic                    cfg_diff;
    logic                    load;
    logic                    adv;
    logic                    step;

    assign cfg_mode[0] = act_mode_q;
    assign cfg_mode[1] = ssc_mode_e'(mode_i);

    for (genvar g = 0; g < NCFG; g++) begin : g_dec
        ssc_mode_decode #(.LVL_W(LVL_W)) dec_i (
            .mode_i (cfg_mode[g]),
            .span_o (cfg_span[g]),
            .down_o (cfg_down[g])
        );
    end

    // Offset from level: trough is -span (down) or -span/2 (centre)
    always_comb begin
        base     = -$signed(OFS_W'(cfg_down[0] ? cfg_span[0] : (cfg_span[0] >> 1)));
        offset_o = act_en_q ? (base + $signed(OFS_W'(level))) : '0;
    end

    // Decide whether a pending configuration is taken this cycle
    always_comb begin
        at_zero  = (offset_o == '0);
        cfg_diff = (spread_en_i != act_en_q) ||
                   (spread_en_i && (cfg_mode[1] != act_mode_q));
        load     = at_zero && cfg_diff;
        adv      = act_en_q && !load;
        load_lvl = cfg_down[1] ? cfg_span[1] : (cfg_span[1] >> 1);
    end

    // Active configuration registers
    always_ff @(posedge clk_i) begin
        if (!rst_n_i) begin
            act_en_q   <= 1'b0;
            act_mode_q <= SSC_CTR_WIDE;
        end else if (load) begin
            act_en_q   <= spread_en_i;
            act_mode_q <= cfg_mode[1];
        end
    end

    ssc_half_period #(.PER_W(PER_W), .LVL_W(LVL_W)) half_i (
        .period_i (period_i),
        .span_i   (cfg_span[0]),
        .half_o   (half)
    );

    ssc_frac_step #(.PER_W(PER_W), .LVL_W(LVL_W)) step_i (
        .clk_i   (clk_i),
        .rst_n_i (rst_n_i),
        .adv_i   (adv),
        .clr_i   (load),
        .span_i  (cfg_span[0]),
        .half_i  (half),
        .step_o  (step)
    );

    ssc_tri_seq #(.LVL_W(LVL_W)) seq_i (
        .clk_i      (clk_i),
        .rst_n_i    (rst_n_i),
        .load_i     (load),
        .load_lvl_i (load_lvl),
        .load_up_i  (!cfg_down[1]),
        .step_i     (step),
        .span_i     (cfg_span[0]),
        .level_o    (level),
        .turn_o     (turn_o)
    );
endmodule

// File: rtl/ssc_profile_chk.sv
// Property checker for ssc_profile_gen, attached by bind.
// Watches the ports plus the active configuration registers.
module ssc_profile_chk #(
    parameter int OFS_W = 12
) (
    input logic                    clk_i,
    input logic                    rst_n_i,
    input logic                    spread_en_i,
    input logic signed [OFS_W-1:0] offset_o,
    input logic                    turn_o,
    input logic                    act_en_q,
    input logic [1:0]              act_mode_q
);
    int hi;
    int lo;

    // Expected extremes of the active profile
    always_comb begin
        case (act_mode_q)
            2'b00:   begin hi = 150; lo = -150; end
            2'b01:   begin hi = 50;  lo = -50;  end
            2'b10:   begin hi = 0;   lo = -100; end
            default: begin hi = 0;   lo = -300; end
        endcase
    end

    AST_STEP_LIMIT: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        $past(rst_n_i) |-> ((offset_o <= $past(offset_o) + 1) && (offset_o >= $past(offset_o) - 1))); // R6

    AST_WIDE_BOUND: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        (act_en_q && act_mode_q == 2'b00) |-> (offset_o <= 150 && offset_o >= -150)); // R2

    AST_NARROW_BOUND: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        (act_en_q && act_mode_q == 2'b01) |-> (offset_o <= 50 && offset_o >= -50)); // R3

    AST_SHALLOW_DOWN: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        (act_en_q && act_mode_q == 2'b10) |-> (offset_o <= 0 && offset_o >= -100)); // R4

    AST_DEEP_DOWN: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        (act_en_q && act_mode_q == 2'b11) |-> (offset_o <= 0 && offset_o >= -300)); // R5

    AST_TURN_AT_EXTREME: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        turn_o |-> (offset_o == hi || offset_o == lo)); // R8

    AST_TURN_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        turn_o |=> !turn_o); // R8

    AST_OFF_STAYS_ZERO: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        ($past(rst_n_i) && !$past(spread_en_i) && ($past(offset_o) == 0)) |-> (offset_o == 0 && !turn_o)); // R9

    AST_CFG_HOLD: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        ($past(rst_n_i) && ($past(offset_o) != 0)) |-> ($stable(act_mode_q) && $stable(act_en_q))); // R10
endmodule

bind ssc_profile_gen ssc_profile_chk #(.OFS_W(OFS_W)) chk_i (
    .clk_i       (clk_i),
    .rst_n_i     (rst_n_i),
    .spread_en_i (spread_en_i),
    .offset_o    (offset_o),
    .turn_o      (turn_o),
    .act_en_q    (act_en_q),
    .act_mode_q  (act_mode_q)
);

// File: tb/ssc_profile_gen_tb.sv
`timescale 1ns/1ps
// Self-checking bench for ssc_profile_gen: a vector table of profile and
// period settings, then directed tests for reset, deferral and enable.
module ssc_profile_gen_tb_top;
    localparam int PER_W = 16;
    localparam int OFS_W = 12;
    localparam int WAIT_LIMIT = 20000;
    localparam int WDOG_CYCLES = 190000;

    typedef struct packed {
        logic [1:0]  mode;
        logic [15:0] period;
        int          hi;
        int          lo;
        int          half;
        logic        clamp;
    } vec_t;

    localparam int NVEC = 7;
    localparam vec_t VECS [NVEC] = '{
        '{2'b00, 16'd1000, 150, -150, 500,  1'b0},
        '{2'b01, 16'd1001, 50,  -50,  500,  1'b0},
        '{2'b10, 16'd800,  0,   -100, 400,  1'b0},
        '{2'b11, 16'd2000, 0,   -300, 1000, 1'b0},
        '{2'b11, 16'd100,  0,   -300, 300,  1'b1},
        '{2'b01, 16'd60,   50,  -50,  100,  1'b1},
        '{2'b00, 16'd4096, 150, -150, 2048, 1'b0}
    };

    logic                    clk = 1'b0;
    logic                    rst_n;
    logic [1:0]              mode;
    logic                    spread_en;
    logic [PER_W-1:0]        period;
    logic signed [OFS_W-1:0] offset;
    logic                    turn;

    int n_checks = 0;
    int n_errors = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    ssc_profile_gen #(.PER_W(PER_W), .OFS_W(OFS_W)) dut_i (
        .clk_i       (clk),
        .rst_n_i     (rst_n),
        .mode_i      (mode),
        .spread_en_i (spread_en),
        .period_i    (period),
        .offset_o    (offset),
        .turn_o      (turn)
    );

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic check(input string req, input string what, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic wait_turn(input string req);
        int n = 0;
        do begin
            tick();
            n++;
        end while (!turn && n < WAIT_LIMIT);
        if (!turn) check(req, "strobe timeout", 0, 1);
    endtask

    task automatic wait_offset(input string req, input int val, input bit nonzero);
        int n = 0;
        while ((nonzero ? (offset == 0) : (int'(offset) != val)) && n < WAIT_LIMIT) begin
            tick();
            n++;
        end
        if (n >= WAIT_LIMIT) check(req, "offset wait timeout", int'(offset), val);
    endtask

    // Watchdog: counts as a failure and still prints the summary
    initial begin
        repeat (WDOG_CYCLES) @(posedge clk);
        if (!finished) begin
            n_errors++;
            $display("FAIL watchdog: actual %0d expected %0d cycles", WDOG_CYCLES, 0);
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    end

    initial begin
        string rtag [4] = '{"R2", "R3", "R4", "R5"};
        rst_n = 1'b0; spread_en = 1'b1; mode = 2'b00; period = 16'd1000;

        // R1: reset state
        repeat (4) tick();
        check("R1", "offset in reset", int'(offset), 0);
        check("R1", "turn in reset", int'(turn), 0);
        rst_n = 1'b1;
        tick();
        check("R11", "offset at start", int'(offset), 0);
        wait_offset("R11", 1, 1'b1);
        check("R11", "first centre value", int'(offset), 1);

        // Vector table: bounds, spacing and strobe placement per profile
        for (int v = 0; v < NVEC; v++) begin
            int mx, mn, s1, s2, at_turn;
            string tg;
            string tgs;
            tg  = rtag[VECS[v].mode];
            tgs = VECS[v].clamp ? "R7" : "R6";
            mode = VECS[v].mode; period = VECS[v].period;
            wait_turn(tg);
            wait_turn(tg);
            wait_turn(tg);
            at_turn = int'(offset);
            mx = at_turn; mn = at_turn;
            tick();
            check("R8", "strobe width", int'(turn), 0);
            if (offset > mx) mx = offset;
            if (offset < mn) mn = offset;
            s1 = 1;
            while (!turn && s1 < WAIT_LIMIT) begin
                tick(); s1++;
                if (offset > mx) mx = offset;
                if (offset < mn) mn = offset;
            end
            s2 = 0;
            do begin
                tick(); s2++;
                if (offset > mx) mx = offset;
                if (offset < mn) mn = offset;
            end while (!turn && s2 < WAIT_LIMIT);
            check(tgs, "rise/fall spacing 1", s1, VECS[v].half);
            check(tgs, "rise/fall spacing 2", s2, VECS[v].half);
            check(tg, "profile maximum", mx, VECS[v].hi);
            check(tg, "profile minimum", mn, VECS[v].lo);
            check("R8", "strobe at extreme", int'(at_turn == VECS[v].hi || at_turn == VECS[v].lo), 1);
        end

        // R10: change requested away from zero is deferred
        period = 16'd1000;
        wait_offset("R10", 120, 1'b0);
        mode = 2'b01;
        tick();
        check("R10", "no jump after deferred change", int'(offset >= 119 && offset <= 121), 1);
        wait_offset("R10", 0, 1'b0);
        wait_turn("R10");
        check("R10", "narrow extreme after change", int'(offset == 50 || offset == -50), 1);

        // R9: disable at the trough of a down profile
        mode = 2'b10; period = 16'd800;
        wait_turn("R9");
        wait_turn("R9");
        if (offset != -100) wait_turn("R9");
        spread_en = 1'b0;
        tick();
        check("R9", "no immediate drop to zero", int'(offset <= -99 && offset >= -100), 1);
        wait_offset("R9", 0, 1'b0);
        begin
            int bad = 0;
            for (int i = 0; i < 2000; i++) begin
                tick();
                if (offset != 0 || turn) bad++;
            end
            check("R9", "disabled cycles with activity", bad, 0);
        end
        mode = 2'b11; period = 16'd700;
        repeat (50) tick();
        check("R9", "mode change while disabled", int'(offset), 0);

        // R11: down profile starts by falling
        spread_en = 1'b1;
        tick();
        wait_offset("R11", -1, 1'b1);
        check("R11", "first down value", int'(offset), -1);

        // R1: reset in mid-run
        repeat (37) tick();
        rst_n = 1'b0;
        tick();
        check("R1", "offset after mid-run reset", int'(offset), 0);
        check("R1", "turn after mid-run reset", int'(turn), 0);
        rst_n = 1'b1;
        repeat (3) tick();

        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end
endmodule